// File: doc/BRIEF.md
# Duty-Cycled Oscillator Burst Sequencer

This block sequences the switch and strobe controls for a burst-mode oscillator. It runs on a clock at twice the reference rate, so one reference cycle is two ticks. Each period lasts N reference cycles and holds one oscillator burst that is exactly one reference cycle long. The burst follows a preset interval in which the bias DAC and then the bias-capacitor switches are brought up. After the burst the loop opens, the capacitor switches release and the DAC shuts down, each a tick apart. The edge-counter clear, the count-sample strobe and the deferred control-word update strobe are placed around the burst.

Every output is a register. Ticks are numbered 0 to 2N-1 inside a period, with tick 0 the first tick of the preset. A period length written on `period_cfg` is applied only at a period boundary or when the sequence starts from idle. A low `enable` drops every output to idle on the next tick.

Top module: `burst_seq`

## Requirements
- R1: With `enable` held high and a period length N, the output pattern repeats every 2N ticks, and `loop_close` rises exactly once per period.
- R2: `dac_en` is high from tick 0, which is one reference cycle (two ticks) before `loop_close` rises.
- R3: `bias_sw_close` goes high at tick 1, half a reference cycle after the preset starts.
- R4: `dline_release` and `loop_close` rise together at tick 2 and are both high for exactly ticks 2 and 3.
- R5: After the burst, `loop_close` is low from tick 4, `bias_sw_close` is low from tick 5 and `dac_en` is low from tick 6. This leaves one tick of dead time between each step.
- R6: `count_clear` is high on ticks 0 and 1 only, so it is never high while the loop is closed.
- R7: `count_sample` is a single-tick pulse at tick 4. `word_update` is a single-tick pulse at tick 6, one reference cycle after the burst ends.
- R8: `loop_close` is high only while `bias_sw_close` and `dac_en` are both high, and `bias_sw_close` is high only while `dac_en` is high.
- R9: A `period_cfg` value below 4 is treated as 4. A value written during a period takes effect at the next tick 0 and leaves the current period's length unchanged.
- R10: Reset, or `enable` sampled low, makes all seven outputs low from the next tick. When `enable` rises from idle, the tick after the rising edge is tick 0 of a new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock at twice the reference rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the sequence when high; forces idle when low |
| period_cfg | input | PW (8) | Period length N in reference cycles |
| dac_en | output | 1 | Bias DAC enable |
| bias_sw_close | output | 1 | Closes the switches to the bias capacitors |
| dline_release | output | 1 | Releases the delay-line input from its idle levels |
| loop_close | output | 1 | Closes the feedback from the last stage to the first |
| count_clear | output | 1 | Clears the edge counter |
| count_sample | output | 1 | Strobe that samples the edge count |
| word_update | output | 1 | Strobe that updates the control word |

## Verification
The hardest case to reach is a change of period length that lands in the middle of a period. The old length must govern the rest of that period and the new one must apply from the next tick 0. The bench writes a new `period_cfg` at tick 3 of a running period. It then walks every tick through that period, the whole following period and the start of the one after. This shows where the wrap happens. A second hard case is dropping `enable` in the middle of the burst. The bench does this while the loop is closed, checks that everything goes idle at once, and then checks a clean restart at tick 0.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // tick positions inside a period (two ticks per reference cycle)
  localparam int unsigned TK_PRESET   = 0;
  localparam int unsigned TK_BIAS_ON  = 1;
  localparam int unsigned TK_RUN      = 2;
  localparam int unsigned TK_STOP     = 4;
  localparam int unsigned TK_BIAS_OFF = 5;
  localparam int unsigned TK_DAC_OFF  = 6;
  localparam int unsigned TK_USED     = TK_DAC_OFF + 1;

  typedef struct packed {
    logic dac;
    logic bias;
    logic free;
    logic loopc;
    logic clr;
    logic smp;
    logic upd;
  } phase_t;

  // smallest period (reference cycles) that holds every used tick
  function automatic int unsigned min_period();
    return (TK_USED + 1) / 2;
  endfunction

  function automatic logic in_win(int unsigned s, int unsigned lo, int unsigned hi);
    return (s >= lo) && (s < hi);
  endfunction

  function automatic phase_t phase_of(logic active, int unsigned s);
    phase_t p;
    p.dac   = active && in_win(s, TK_PRESET, TK_DAC_OFF);
    p.bias  = active && in_win(s, TK_BIAS_ON, TK_BIAS_OFF);
    p.free  = active && in_win(s, TK_RUN, TK_STOP);
    p.loopc = active && in_win(s, TK_RUN, TK_STOP);
    p.clr   = active && in_win(s, TK_PRESET, TK_RUN);
    p.smp   = active && (s == TK_STOP);
    p.upd   = active && (s == TK_DAC_OFF);
    return p;
  endfunction

endpackage

// File: rtl/burst_period_reg.sv
module burst_period_reg #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] cfg,
  output logic [PW-1:0] cur
);
  import burst_seq_pkg::*;

  localparam logic [PW-1:0] MINP = PW'(min_period());

  logic [PW-1:0] clamped;

  always_comb begin
    clamped = (cfg < MINP) ? MINP : cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= MINP;
    else if (load) cur <= clamped;
  end
endmodule

// File: rtl/burst_slot_counter.sv
module burst_slot_counter #(
  parameter  int unsigned PW = 8,
  localparam int unsigned SW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [PW-1:0] period,
  output logic          run_d,
  output logic [SW-1:0] slot_d,
  output logic          wrap,
  output logic          start
);
  logic          run_q;
  logic [SW-1:0] slot_q;
  logic [SW-1:0] last_slot;

  always_comb begin
    last_slot = {period, 1'b0} - SW'(1);
    wrap      = run_q && enable && (slot_q == last_slot);
    start     = enable && !run_q;
    if (!enable) begin
      run_d  = 1'b0;
      slot_d = '0;
    end else if (!run_q) begin
      run_d  = 1'b1;
      slot_d = '0;
    end else begin
      run_d  = 1'b1;
      slot_d = wrap ? '0 : slot_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slot_q <= '0;
    end else begin
      run_q  <= run_d;
      slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/burst_phase_decode.sv
module burst_phase_decode #(
  parameter int unsigned SW = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_d,
  input  logic [SW-1:0]         slot_d,
  output burst_seq_pkg::phase_t ph_q
);
  import burst_seq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= phase_of(run_d, 32'(slot_d));
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [PW-1:0] period_cfg,
  output logic          dac_en,
  output logic          bias_sw_close,
  output logic          dline_release,
  output logic          loop_close,
  output logic          count_clear,
  output logic          count_sample,
  output logic          word_update
);
  import burst_seq_pkg::*;

  localparam int unsigned SW = PW + 1;

  // named internal events
  logic          period_wrap;
  logic          period_start;
  logic [PW-1:0] cur_period;
  logic          run_next;
  logic [SW-1:0] slot_next;
  phase_t        ph;

  burst_period_reg #(.PW(PW)) period_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (period_wrap || period_start),
    .cfg   (period_cfg),
    .cur   (cur_period)
  );

  burst_slot_counter #(.PW(PW)) slot_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .period (cur_period),
    .run_d  (run_next),
    .slot_d (slot_next),
    .wrap   (period_wrap),
    .start  (period_start)
  );

  burst_phase_decode #(.SW(SW)) decode_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_d  (run_next),
    .slot_d (slot_next),
    .ph_q   (ph)
  );

  assign dac_en        = ph.dac;
  assign bias_sw_close = ph.bias;
  assign dline_release = ph.free;
  assign loop_close    = ph.loopc;
  assign count_clear   = ph.clr;
  assign count_sample  = ph.smp;
  assign word_update   = ph.upd;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic dac_en,
  input logic bias_sw_close,
  input logic dline_release,
  input logic loop_close,
  input logic count_clear,
  input logic count_sample,
  input logic word_update
);
  p_preset_dac_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_close) |-> $past(dac_en, 2) && $past(dac_en));
  p_bias_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_close) |-> $past(bias_sw_close) && !$past(bias_sw_close, 2));
  p_free_with_loop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_close) |-> $rose(dline_release));
  p_burst_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_close) && enable |=> loop_close);
  p_burst_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_close && $past(loop_close) |=> !loop_close);
  p_dead_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loop_close) && $past(enable) |-> bias_sw_close);
  p_dac_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bias_sw_close) && $past(enable) |-> dac_en);
  p_clear_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count_clear |-> !loop_close);
  p_sample_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count_sample |-> $past(loop_close) && !loop_close);
  p_update_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_update |-> $past(dac_en) && !dac_en && !bias_sw_close);
  p_update_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_update |=> !word_update);
  p_loop_in_bias_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_close |-> bias_sw_close && dac_en);
  p_bias_in_dac_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bias_sw_close |-> dac_en);
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !dac_en && !bias_sw_close && !dline_release && !loop_close
                && !count_clear && !count_sample && !word_update);
endmodule

bind burst_seq burst_seq_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .dac_en        (dac_en),
  .bias_sw_close (bias_sw_close),
  .dline_release (dline_release),
  .loop_close    (loop_close),
  .count_clear   (count_clear),
  .count_sample  (count_sample),
  .word_update   (word_update)
);

// File: tb/burst_seq_tb_top.sv
`timescale 1ns/1ps
module burst_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] period_cfg = 8'd10;
  logic dac_en, bias_sw_close, dline_release, loop_close;
  logic count_clear, count_sample, word_update;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  burst_seq #(.PW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period_cfg(period_cfg),
    .dac_en(dac_en), .bias_sw_close(bias_sw_close), .dline_release(dline_release),
    .loop_close(loop_close), .count_clear(count_clear),
    .count_sample(count_sample), .word_update(word_update)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected level of every output at tick t of a running period
  task automatic check_tick(input int t, input string tag);
    string w;
    w = $sformatf("%s tick %0d", tag, t);
    check("R2/R5", {w, " dac_en"},        dac_en,        (t <= 5) ? 1 : 0);
    check("R3/R5", {w, " bias_sw_close"}, bias_sw_close, (t >= 1 && t <= 4) ? 1 : 0);
    check("R4",    {w, " dline_release"}, dline_release, (t == 2 || t == 3) ? 1 : 0);
    check("R4",    {w, " loop_close"},    loop_close,    (t == 2 || t == 3) ? 1 : 0);
    check("R6",    {w, " count_clear"},   count_clear,   (t < 2) ? 1 : 0);
    check("R7",    {w, " count_sample"},  count_sample,  (t == 4) ? 1 : 0);
    check("R7",    {w, " word_update"},   word_update,   (t == 6) ? 1 : 0);
    check("R8",    {w, " nesting"},
          ((!loop_close || (bias_sw_close && dac_en)) && (!bias_sw_close || dac_en)) ? 1 : 0, 1);
  endtask

  task automatic check_idle(input string what);
    check("R10", what,
          {25'd0, dac_en, bias_sw_close, dline_release, loop_close,
           count_clear, count_sample, word_update}, 0);
  endtask

  task automatic go_idle();
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    check_idle("idle after disable");
  endtask

  // R1 / R9: full periods of length n (effective), from idle
  task automatic t_periods(input int cfg, input int n, input int periods, input string tag);
    int rises = 0;
    logic prev = 1'b0;
    @(negedge clk) begin period_cfg = 8'(cfg); enable = 1'b1; end
    for (int p = 0; p < periods; p++) begin
      for (int t = 0; t < 2 * n; t++) begin
        @(negedge clk);
        check_tick(t, tag);
        if (loop_close && !prev) rises++;
        prev = loop_close;
      end
    end
    check("R1", {tag, " loop_close rises"}, rises, periods);
    go_idle();
  endtask

  // R9: new length written mid-period is applied at the next tick 0
  task automatic t_change();
    @(negedge clk) begin period_cfg = 8'd5; enable = 1'b1; end
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      check_tick(t, "R9 old period");
      if (t == 3) period_cfg = 8'd7;
    end
    for (int t = 0; t < 14; t++) begin
      @(negedge clk);
      check_tick(t, "R9 new period");
    end
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      check_tick(t, "R9 after new period");
    end
    go_idle();
  endtask

  // R10: abort during burst, then restart from tick 0
  task automatic t_abort();
    @(negedge clk) begin period_cfg = 8'd6; enable = 1'b1; end
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      check_tick(t, "R10 before abort");
    end
    enable = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_idle("R10 after abort");
    end
    enable = 1'b1;
    for (int t = 0; t < 12; t++) begin
      @(negedge clk);
      check_tick(t, "R10 restart");
    end
    go_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R10 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R10 idle while disabled");
    t_periods(10, 10, 3, "R1 N=10");
    t_periods(4, 4, 3, "R1 N=4");
    t_periods(2, 4, 2, "R9 clamp N=2");
    t_periods(0, 4, 2, "R9 clamp N=0");
    t_periods(255, 255, 1, "R1 N=255");
    t_change();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule